// File: doc/BRIEF.md
# Sync-Detecting Receive Packet Handler

This block sits behind a demodulator and clock-recovery stage and turns a serial bit stream, delivered one bit per strobe, into bytes for a receive FIFO. A start command arms it. It then compares a 16-bit window of incoming bits against a programmed sync pattern. From the bit right after the sync pattern onward, it packs bits into bytes and pushes them to the FIFO. It leaves out the trailing checksum bytes, and it can also leave out the length byte.

Three framing modes are selectable at start. The first has a fixed payload length from a configuration input. The second takes a variable length from the first byte after sync. The third is an endless mode: it stores every byte until the next start command and never checks a checksum. At the end of a framed packet the block pulses a packet-done output. It flags a checksum mismatch and presents a 4-bit follow-on state code that was captured at start. If the FIFO reports full, bytes are dropped and a sticky overflow flag is raised.

Top module: `rx_pkt_handler`

## Requirements
- R1: After reset all outputs are zero, and no byte is written until a start command has been given and a sync pattern found.
- R2: A byte is stored only after the full SYNC_W-bit window, taken most significant bit first, equals `sync_word_i`. The first payload bit is the one after the final sync bit. Partial matches and bits sent before start store nothing.
- R3: In mode 0 (code 3 acts the same), exactly `fixed_len_i` payload bytes are stored. The two checksum bytes that follow are never stored. `pkt_rx_o` is a single-cycle pulse at completion.
- R4: In mode 1, the first byte after sync is the payload length. It is stored ahead of the payload unless `strip_len_i` was set at start.
- R5: The checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first with no reflection. It covers the length byte (mode 1) and the payload, and is received high byte first. A mismatch sets `crc_err_o` in the same cycle as `pkt_rx_o`. A start command clears it.
- R6: In mode 2, every byte after sync is stored with no end, including bytes that equal the sync pattern. No `pkt_rx_o` and no `crc_err_o` are produced.
- R7: A start command aborts any packet in progress and re-arms the sync search. This is the only way to leave mode 2.
- R8: At completion, `state_code_o` takes the `valid_state_i` value captured at start. It changes at no other time.
- R9: A byte due for storage while `fifo_full_i` is high is dropped and sets `overflow_o`. That flag stays set until the next start command.
- R10: A payload length of zero, from either source, makes the two bytes after sync (mode 0) or after the length byte (mode 1) the checksum.
- R11: Data bits are packed most significant bit first into each stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-receive command; captures configuration and arms sync search |
| mode_i | input | 2 | Framing mode: 0 fixed, 1 variable, 2 endless, 3 fixed |
| strip_len_i | input | 1 | Mode 1: keep the length byte out of the FIFO |
| fixed_len_i | input | LEN_W | Payload length for mode 0 |
| valid_state_i | input | 4 | Follow-on state code presented on completion |
| sync_word_i | input | SYNC_W | Sync pattern |
| bit_valid_i | input | 1 | Bit strobe |
| bit_i | input | 1 | Received bit |
| fifo_full_i | input | 1 | FIFO cannot accept a byte |
| fifo_wr_o | output | 1 | FIFO write enable |
| fifo_data_o | output | 8 | FIFO write data |
| pkt_rx_o | output | 1 | Packet-received pulse |
| crc_err_o | output | 1 | Checksum mismatch on the last packet |
| overflow_o | output | 1 | Sticky byte-dropped flag |
| state_code_o | output | 4 | Follow-on state code after the last packet |

## Verification
The bench uses the default SYNC_W=16 and LEN_W=8 with sync pattern 0xD391. Because the lengths swept are small (0 to 6), every payload length, both checksum outcomes, both length-strip settings and each mode can be covered in a few tens of thousands of cycles. Short lengths also place the zero-length and single-byte boundaries inside the sweep. An aborted packet, an endless stream that contains the sync pattern, and a packet sent into a full FIFO complete the set.

// File: rtl/rxph_pkg.sv
package rxph_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef enum logic [1:0] {
    RX_FIXED = 2'd0,
    RX_VAR   = 2'd1,
    RX_INF   = 2'd2,
    RX_FIX2  = 2'd3
  } rx_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEARCH, ST_LEN, ST_BODY, ST_CRC_HI, ST_CRC_LO
  } ph_state_e;

  function automatic logic [CRC_W-1:0] crc16_next(logic [CRC_W-1:0] c, logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < BYTE_W; k++)
      r = r[CRC_W-1] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/rxph_sync_match.sv
module rxph_sync_match #(
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  output logic              hit_o
);
  localparam int CW = $clog2(SYNC_W + 1);
  localparam logic [CW-1:0] FULL = CW'(SYNC_W - 1);

  logic [SYNC_W-1:0] win_q;
  logic [CW-1:0]     fill_q;
  logic [SYNC_W-1:0] win_next;

  assign win_next = {win_q[SYNC_W-2:0], bit_i};
  assign hit_o    = shift_en && (fill_q == FULL) && (win_next == sync_word_i);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      win_q <= win_next;
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxph_byte_pack.sv
module rxph_byte_pack #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          bit_i,
  output logic          byte_v_o,
  output logic [BW-1:0] byte_o
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      byte_v_o <= 1'b0;
      byte_o   <= '0;
    end else begin
      byte_v_o <= 1'b0;
      if (en) begin
        sh_q  <= {sh_q[BW-2:0], bit_i};
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          byte_v_o <= 1'b1;
          byte_o   <= {sh_q[BW-2:0], bit_i};
        end
      end
    end
  end
endmodule

// File: rtl/rxph_crc16.sv
module rxph_crc16
  import rxph_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              upd,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  always_ff @(posedge clk) begin
    if (rst || init) crc_o <= 16'hFFFF;
    else if (upd)    crc_o <= crc16_next(crc_o, data_i);
  end
endmodule

// File: rtl/rx_pkt_handler.sv
module rx_pkt_handler
  import rxph_pkg::*;
#(
  parameter int SYNC_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              strip_len_i,
  input  logic [LEN_W-1:0]  fixed_len_i,
  input  logic [3:0]        valid_state_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [7:0]        fifo_data_o,
  output logic              pkt_rx_o,
  output logic              crc_err_o,
  output logic              overflow_o,
  output logic [3:0]        state_code_o
);
  ph_state_e         state_q;
  rx_mode_e          mode_q;
  logic              strip_q;
  logic [LEN_W-1:0]  flen_q;
  logic [LEN_W-1:0]  remain_q;
  logic [3:0]        vstate_q;
  logic [BYTE_W-1:0] crc_hi_q;

  logic              sync_hit;
  logic              pack_en;
  logic              byte_v;
  logic [BYTE_W-1:0] byte_d;
  logic              crc_upd;
  logic [CRC_W-1:0]  crc_val;
  logic              push_req;

  assign pack_en  = bit_valid_i && (state_q inside {ST_LEN, ST_BODY, ST_CRC_HI, ST_CRC_LO});
  assign crc_upd  = byte_v && (state_q inside {ST_LEN, ST_BODY});
  assign push_req = byte_v && ((state_q == ST_BODY) || (state_q == ST_LEN && !strip_q));

  rxph_sync_match #(.SYNC_W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .clr(start_i),
    .shift_en(bit_valid_i && state_q == ST_SEARCH),
    .bit_i(bit_i), .sync_word_i(sync_word_i), .hit_o(sync_hit)
  );

  rxph_byte_pack #(.BW(BYTE_W)) u_pack (
    .clk(clk), .rst(rst), .clr(start_i || sync_hit), .en(pack_en),
    .bit_i(bit_i), .byte_v_o(byte_v), .byte_o(byte_d)
  );

  rxph_crc16 u_crc (
    .clk(clk), .rst(rst), .init(start_i || sync_hit), .upd(crc_upd),
    .data_i(byte_d), .crc_o(crc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_q       <= RX_FIXED;
      strip_q      <= 1'b0;
      flen_q       <= '0;
      remain_q     <= '0;
      vstate_q     <= '0;
      crc_hi_q     <= '0;
      fifo_wr_o    <= 1'b0;
      fifo_data_o  <= '0;
      pkt_rx_o     <= 1'b0;
      crc_err_o    <= 1'b0;
      overflow_o   <= 1'b0;
      state_code_o <= '0;
    end else begin
      fifo_wr_o <= 1'b0;
      pkt_rx_o  <= 1'b0;
      if (start_i) begin
        state_q    <= ST_SEARCH;
        mode_q     <= rx_mode_e'(mode_i);
        strip_q    <= strip_len_i;
        flen_q     <= fixed_len_i;
        vstate_q   <= valid_state_i;
        crc_err_o  <= 1'b0;
        overflow_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_SEARCH: if (sync_hit) begin
            if (mode_q == RX_VAR)      state_q <= ST_LEN;
            else if (mode_q == RX_INF) state_q <= ST_BODY;
            else if (flen_q == '0)     state_q <= ST_CRC_HI;
            else begin
              state_q  <= ST_BODY;
              remain_q <= flen_q;
            end
          end
          ST_LEN: if (byte_v) begin
            remain_q <= LEN_W'(byte_d);
            state_q  <= (byte_d == '0) ? ST_CRC_HI : ST_BODY;
          end
          ST_BODY: if (byte_v && mode_q != RX_INF) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == LEN_W'(1)) state_q <= ST_CRC_HI;
          end
          ST_CRC_HI: if (byte_v) begin
            crc_hi_q <= byte_d;
            state_q  <= ST_CRC_LO;
          end
          ST_CRC_LO: if (byte_v) begin
            pkt_rx_o     <= 1'b1;
            crc_err_o    <= ({crc_hi_q, byte_d} != crc_val);
            state_code_o <= vstate_q;
            state_q      <= ST_IDLE;
          end
          default: ;
        endcase
        if (push_req) begin
          if (fifo_full_i) overflow_o <= 1'b1;
          else begin
            fifo_wr_o   <= 1'b1;
            fifo_data_o <= byte_d;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rxph_checks.sv
module rxph_checks (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       fifo_full_i,
  input logic       fifo_wr_o,
  input logic       pkt_rx_o,
  input logic       crc_err_o,
  input logic       overflow_o,
  input logic [3:0] state_code_o,
  input logic [1:0] mode_q
);
  a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_o |-> !$past(fifo_full_i));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pkt_rx_o |=> !pkt_rx_o);
  a_r5_err_with_pkt: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_err_o) |-> pkt_rx_o);
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !start_i) |=> overflow_o);
  a_r9_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow_o) |-> $past(fifo_full_i));
  a_r8_code_on_pkt: assert property (@(posedge clk) disable iff (rst)
    !$stable(state_code_o) |-> pkt_rx_o);
  a_r6_no_pkt_endless: assert property (@(posedge clk) disable iff (rst)
    pkt_rx_o |-> (mode_q != 2'd2));
  a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!crc_err_o && !overflow_o && !pkt_rx_o));
endmodule

bind rx_pkt_handler rxph_checks u_rxph_checks (
  .clk(clk), .rst(rst), .start_i(start_i), .fifo_full_i(fifo_full_i),
  .fifo_wr_o(fifo_wr_o), .pkt_rx_o(pkt_rx_o), .crc_err_o(crc_err_o),
  .overflow_o(overflow_o), .state_code_o(state_code_o), .mode_q(mode_q)
);

// File: tb/test_rx_pkt_handler.sv
module test_rx_pkt_handler;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start_i, strip_len_i, bit_valid_i, bit_i, fifo_full_i;
  logic [1:0] mode_i;
  logic [7:0] fixed_len_i;
  logic [3:0] valid_state_i;
  logic [15:0] sync_word_i;
  logic fifo_wr_o, pkt_rx_o, crc_err_o, overflow_o;
  logic [7:0] fifo_data_o;
  logic [3:0] state_code_o;

  rx_pkt_handler i_rx_pkt_handler (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .strip_len_i(strip_len_i), .fixed_len_i(fixed_len_i),
    .valid_state_i(valid_state_i), .sync_word_i(sync_word_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i), .fifo_full_i(fifo_full_i),
    .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .pkt_rx_o(pkt_rx_o),
    .crc_err_o(crc_err_o), .overflow_o(overflow_o), .state_code_o(state_code_o)
  );

  int checks = 0, fails = 0;
  logic [7:0] got [0:255];
  logic [7:0] expb [0:63];
  int ngot = 0, npkt = 0, nexp = 0;
  logic last_err = 1'b0;
  logic [3:0] last_code = 4'd0;

  always @(negedge clk) if (!rst) begin
    if (fifo_wr_o) begin
      if (ngot < 256) got[ngot] = fifo_data_o;
      ngot++;
    end
    if (pkt_rx_o) begin
      npkt++;
      last_err  = crc_err_o;
      last_code = state_code_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid_i = 1'b1; bit_i = b;
    @(negedge clk); bit_valid_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic start_rx(input int mode, input bit strip, input int flen, input int vs);
    @(negedge clk);
    mode_i = 2'(mode); strip_len_i = strip; fixed_len_i = 8'(flen);
    valid_state_i = 4'(vs); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    ngot = 0; npkt = 0; nexp = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic compare_bytes(input string req);
    check(ngot == nexp, {req, " byte count"}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      check(got[i] == expb[i], {req, " byte value"}, got[i], expb[i]);
  endtask

  // R3 R4 R5 R8 R10 R11: full framed packet with independent reference
  task automatic run_pkt(input int mode, input bit strip, input int len, input bit bad, input int vs);
    logic [15:0] c = 16'hFFFF;
    logic [7:0] b;
    start_rx(mode, strip, (mode == 1) ? 9 : len, vs);
    send_byte(8'hAA); send_byte(8'hD3); send_byte(8'h91);
    if (mode == 1) begin
      b = 8'(len);
      c = ref_crc(c, b);
      if (!strip) begin expb[nexp] = b; nexp++; end
      send_byte(b);
    end
    for (int i = 0; i < len; i++) begin
      b = 8'(len * 37 + i * 11 + mode * 5 + 3);
      c = ref_crc(c, b);
      expb[nexp] = b; nexp++;
      send_byte(b);
    end
    c = c ^ (bad ? 16'h0100 : 16'h0000);
    send_byte(c[15:8]); send_byte(c[7:0]);
    settle();
    compare_bytes("R3/R4/R11");
    check(npkt == 1, "R3 pkt pulse count", npkt, 1);
    check(last_err == bad, "R5 crc flag", int'(last_err), int'(bad));
    check(last_code == 4'(vs), "R8 state code", last_code, vs);
    if (len == 0) check(ngot == ((mode == 1 && !strip) ? 1 : 0), "R10 zero length", ngot, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; mode_i = 2'd0; strip_len_i = 1'b0;
    fixed_len_i = 8'd0; valid_state_i = 4'd0; sync_word_i = 16'hD391;
    bit_valid_i = 1'b0; bit_i = 1'b0; fifo_full_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!fifo_wr_o && !pkt_rx_o && !crc_err_o && !overflow_o && state_code_o == 0,
          "R1 reset outputs", {fifo_wr_o, pkt_rx_o, crc_err_o, overflow_o, state_code_o}, 0);

    // R1 R2: sync sent before any start stores nothing
    send_byte(8'hD3); send_byte(8'h91); send_byte(8'h55); send_byte(8'h66);
    settle();
    check(ngot == 0 && npkt == 0, "R1 no store before start", ngot, 0);

    // R2: near-miss sync patterns store nothing
    start_rx(0, 0, 2, 5);
    send_byte(8'hD3); send_byte(8'h90); send_byte(8'h53); send_byte(8'h91);
    send_byte(8'hC3); send_byte(8'h91); send_byte(8'h12);
    settle();
    check(ngot == 0, "R2 partial sync ignored", ngot, 0);

    // sweeps over lengths, modes, strip and checksum outcome
    for (int len = 0; len <= 6; len++)
      for (int bad = 0; bad < 2; bad++) begin
        run_pkt(0, 1'b0, len, bit'(bad), (len + bad) & 15);
        run_pkt(3, 1'b0, len, bit'(bad), (len * 3 + 1) & 15);
        run_pkt(1, 1'b0, len, bit'(bad), (len + 7) & 15);
        run_pkt(1, 1'b1, len, bit'(bad), (len + 11) & 15);
      end

    // R6: endless mode stores everything, incl. sync-like bytes
    start_rx(2, 0, 1, 9);
    send_byte(8'hAA); send_byte(8'hD3); send_byte(8'h91);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b = (i == 3) ? 8'hD3 : (i == 4) ? 8'h91 : 8'(i * 29 + 1);
      expb[nexp] = b; nexp++;
      send_byte(b);
    end
    settle();
    compare_bytes("R6");
    check(npkt == 0 && !crc_err_o, "R6 no pkt no crc", npkt, 0);
    check(state_code_o == 4'((6 + 11) & 15), "R6 state code held", state_code_o, (6 + 11) & 15);

    // R7: restart leaves endless mode and re-arms search
    run_pkt(0, 1'b0, 2, 1'b0, 4);
    check(ngot == 2, "R7 restart from endless", ngot, 2);

    // R7: abort mid-packet
    start_rx(0, 0, 4, 3);
    send_byte(8'hAA); send_byte(8'hD3); send_byte(8'h91); send_byte(8'h42);
    settle();
    check(npkt == 0 && ngot == 1, "R7 in-progress before abort", ngot, 1);
    run_pkt(1, 1'b0, 3, 1'b0, 6);

    // R9: full FIFO drops bytes and sets sticky flag
    fifo_full_i = 1'b1;
    run_pkt(0, 1'b0, 0, 1'b0, 2);
    nexp = 0;
    start_rx(0, 0, 3, 12);
    send_byte(8'hAA); send_byte(8'hD3); send_byte(8'h91);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    send_byte(8'h00); send_byte(8'h00);
    settle();
    check(ngot == 0, "R9 bytes dropped", ngot, 0);
    check(overflow_o == 1'b1, "R9 overflow set", int'(overflow_o), 1);
    check(npkt == 1, "R9 packet still ends", npkt, 1);
    fifo_full_i = 1'b0;
    settle();
    check(overflow_o == 1'b1, "R9 overflow sticky", int'(overflow_o), 1);
    start_rx(0, 0, 1, 0);
    @(negedge clk);
    check(overflow_o == 1'b0, "R9 overflow cleared by start", int'(overflow_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule